// File: doc/BRIEF.md
# Masked packed unsigned minimum unit

This unit takes two packed vectors of up to 512 bits and, lane by lane, keeps the smaller of the two elements when both are read as unsigned numbers. The lanes are 32 or 64 bits wide, and the active vector length is 128, 256 or 512 bits. A write mask can be applied per lane. Lanes that the mask leaves out either keep the old destination value or are cleared, depending on the masking mode. The second operand can also be one scalar, taken from its lowest element, that is broadcast to every lane.

A compatibility mode models the older 128-bit form of the operation. In this mode the old destination value is the first operand and the bits above 128 pass through unchanged. The unit has a one-cycle pipeline. It samples the operands and controls when `in_valid` is high, and it presents the registered 512-bit result with `out_valid` on the next clock.

Top module: `vmin_unit`

## Requirements
- R1: Each active lane compares the first-operand element with the second-operand element as unsigned numbers. It returns the first element only when that element is strictly smaller, and otherwise returns the second element, including when the two are equal.
- R2: With `wide_elem`=0 the lanes are 32 bits. Lane k occupies bits [32k+31:32k], and there are 4, 8 or 16 lanes for `vlen` = 0 (128 bits), 1 (256 bits) or 2 (512 bits). `vlen`=3 acts as 512 bits.
- R3: With `wide_elem`=1 the lanes are 64 bits. Lane k occupies bits [64k+63:64k], and there are 2, 4 or 8 lanes for the same `vlen` codes. Each comparison covers the full 64 bits.
- R4: When `bcast` and `b_mem` are both 1, every lane compares against the lowest element of `src_b`: bits [31:0] for 32-bit lanes and bits [63:0] for 64-bit lanes. When `bcast` is 1 but `b_mem` is 0, `src_b` is used lane by lane.
- R5: A lane receives the minimum when `mask_en`=0, or when its mask bit is 1. Mask bit k belongs to lane k.
- R6: With `mask_en`=1 and `zero_mode`=0, a lane whose mask bit is 0 keeps its value from `dst_old`.
- R7: With `mask_en`=1 and `zero_mode`=1, a lane whose mask bit is 0 is cleared to zero.
- R8: When `legacy`=0, every result bit at or above the active vector length is zero.
- R9: When `legacy`=1, the operation uses 32-bit lanes over 128 bits and takes `dst_old` as the first operand. `src_a`, the mask, broadcast, `wide_elem` and `vlen` have no effect, and result bits [511:128] equal `dst_old[511:128]`.
- R10: Mask bits at and above the lane count for the chosen width and length have no effect on the result.
- R11: `out_valid` is high exactly one clock after `in_valid` is high. The result register changes only on a clock where `in_valid` is high.
- R12: While `rst_n` is low, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_a | input | 512 | First operand vector |
| src_b | input | 512 | Second operand vector |
| dst_old | input | 512 | Previous destination value |
| mask | input | 16 | Per-lane write mask, bit k for lane k |
| wide_elem | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| vlen | input | 2 | Active length: 0=128, 1=256, 2 or 3=512 bits |
| bcast | input | 1 | Broadcast the low element of the second operand |
| b_mem | input | 1 | Second operand is marked as coming from memory |
| mask_en | input | 1 | Apply the write mask |
| zero_mode | input | 1 | Masked-off lanes: 1 clear, 0 keep old value |
| legacy | input | 1 | 128-bit compatibility mode |
| out_valid | output | 1 | Result is valid |
| result | output | 512 | Registered result vector |

## Verification
On every cycle the assertions check the valid timing and the result hold of R11. They also check, whenever an operation is issued, that the bits above 128 are zero for a 128-bit non-legacy operation (R8) and pass through unchanged in legacy mode (R9). Further checks are that an all-zero mask under zero masking gives an all-zero vector (R7), and that an unmasked 32-bit lane never exceeds either of its operands (R1). The bench scenarios cover everything else, because each of these needs a reference result for the whole vector: the choice of operand on ties, the comparison of 64-bit lanes across the 32-bit boundary, broadcast with and without the memory flag, merge values, ignored high mask bits, and the fact that `src_a` is ignored in legacy mode.

// File: rtl/vmin_pkg.sv
package vmin_pkg;

  localparam int unsigned VEC_W  = 512;
  localparam int unsigned SUB_W  = 32;
  localparam int unsigned NSUB   = VEC_W / SUB_W;
  localparam int unsigned NPAIR  = NSUB / 2;
  localparam int unsigned MASK_W = NSUB;
  localparam int unsigned LEG_W  = 128;

  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_MAX = 2'd3
  } vlen_e;

  // Number of 32-bit chunks covered by an active length code.
  function automatic int unsigned active_chunks(input logic [1:0] code);
    case (code)
      VL_128:  active_chunks = 128 / SUB_W;
      VL_256:  active_chunks = 256 / SUB_W;
      default: active_chunks = 512 / SUB_W;
    endcase
  endfunction

endpackage

// File: rtl/vmin_opsel.sv
module vmin_opsel
  import vmin_pkg::*;
#(
  parameter int unsigned P_VEC_W = VEC_W,
  parameter int unsigned P_SUB_W = SUB_W
) (
  input  logic [P_VEC_W-1:0] src_a,
  input  logic [P_VEC_W-1:0] src_b,
  input  logic [P_VEC_W-1:0] dst_old,
  input  logic               wide_elem,
  input  logic               bcast,
  input  logic               b_mem,
  input  logic               legacy,
  output logic [P_VEC_W-1:0] op1,
  output logic [P_VEC_W-1:0] op2,
  output logic               eff_wide
);

  localparam int unsigned LN_SUB = P_VEC_W / P_SUB_W;

  logic bc_on;

  assign bc_on    = bcast && b_mem && !legacy;
  assign eff_wide = wide_elem && !legacy;
  // Compatibility mode: old destination doubles as first operand.
  assign op1      = legacy ? dst_old : src_a;

  for (genvar j = 0; j < LN_SUB; j++) begin : g_chunk
    logic [P_SUB_W-1:0] bc_val;
    // For 64-bit lanes, the odd chunk takes the upper half of the scalar.
    assign bc_val = eff_wide ? src_b[(j%2)*P_SUB_W +: P_SUB_W] : src_b[P_SUB_W-1:0];
    assign op2[j*P_SUB_W +: P_SUB_W] = bc_on ? bc_val : src_b[j*P_SUB_W +: P_SUB_W];
  end

endmodule

// File: rtl/vmin_pair.sv
module vmin_pair #(
  parameter int unsigned P_SUB_W = 32
) (
  input  logic [2*P_SUB_W-1:0] a,
  input  logic [2*P_SUB_W-1:0] b,
  input  logic                 wide,
  output logic [2*P_SUB_W-1:0] m
);

  logic lo_lt, hi_lt, full_lt;
  logic sel_lo, sel_hi;

  assign lo_lt   = a[P_SUB_W-1:0] < b[P_SUB_W-1:0];
  assign hi_lt   = a[2*P_SUB_W-1:P_SUB_W] < b[2*P_SUB_W-1:P_SUB_W];
  assign full_lt = a < b;

  // Strict less picks the first operand; ties go to the second.
  assign sel_lo = wide ? full_lt : lo_lt;
  assign sel_hi = wide ? full_lt : hi_lt;

  assign m[P_SUB_W-1:0]         = sel_lo ? a[P_SUB_W-1:0] : b[P_SUB_W-1:0];
  assign m[2*P_SUB_W-1:P_SUB_W] = sel_hi ? a[2*P_SUB_W-1:P_SUB_W] : b[2*P_SUB_W-1:P_SUB_W];

endmodule

// File: rtl/vmin_lane_ctl.sv
module vmin_lane_ctl
  import vmin_pkg::*;
#(
  parameter int unsigned P_NSUB   = NSUB,
  parameter int unsigned P_MASK_W = MASK_W,
  parameter int unsigned P_LEGSUB = LEG_W / SUB_W
) (
  input  logic [1:0]          vlen,
  input  logic                wide,
  input  logic [P_MASK_W-1:0] mask,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic                legacy,
  output logic [P_NSUB-1:0]   take_min,
  output logic [P_NSUB-1:0]   take_old
);

  int unsigned act_cnt;

  always_comb begin
    act_cnt = active_chunks(vlen);
  end

  for (genvar j = 0; j < P_NSUB; j++) begin : g_ctl
    logic in_len;
    logic mbit;
    logic wr;
    assign in_len = (j < act_cnt);
    // 64-bit lanes own two chunks and share one mask bit.
    assign mbit   = wide ? mask[j/2] : mask[j];
    assign wr     = !mask_en || mbit;

    always_comb begin
      if (legacy) begin
        take_min[j] = (j < P_LEGSUB);
        take_old[j] = (j >= P_LEGSUB);
      end else if (!in_len) begin
        take_min[j] = 1'b0;
        take_old[j] = 1'b0;
      end else begin
        take_min[j] = wr;
        take_old[j] = !wr && !zero_mode;
      end
    end
  end

endmodule

// File: rtl/vmin_unit.sv
module vmin_unit
  import vmin_pkg::*;
#(
  parameter int unsigned P_VEC_W  = VEC_W,
  parameter int unsigned P_SUB_W  = SUB_W,
  parameter int unsigned P_MASK_W = P_VEC_W / P_SUB_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [P_VEC_W-1:0]  src_a,
  input  logic [P_VEC_W-1:0]  src_b,
  input  logic [P_VEC_W-1:0]  dst_old,
  input  logic [P_MASK_W-1:0] mask,
  input  logic                wide_elem,
  input  logic [1:0]          vlen,
  input  logic                bcast,
  input  logic                b_mem,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic                legacy,
  output logic                out_valid,
  output logic [P_VEC_W-1:0]  result
);

  localparam int unsigned L_NSUB  = P_VEC_W / P_SUB_W;
  localparam int unsigned L_NPAIR = L_NSUB / 2;

  logic [P_VEC_W-1:0] op1, op2, mins;
  logic               eff_wide;
  logic [L_NSUB-1:0]  take_min, take_old;
  logic [P_VEC_W-1:0] res_d, res_nxt, res_q;
  logic               vld_nxt, vld_q;

  vmin_opsel #(.P_VEC_W(P_VEC_W), .P_SUB_W(P_SUB_W)) u_opsel (
    .src_a    (src_a),
    .src_b    (src_b),
    .dst_old  (dst_old),
    .wide_elem(wide_elem),
    .bcast    (bcast),
    .b_mem    (b_mem),
    .legacy   (legacy),
    .op1      (op1),
    .op2      (op2),
    .eff_wide (eff_wide)
  );

  for (genvar p = 0; p < L_NPAIR; p++) begin : g_pair
    vmin_pair #(.P_SUB_W(P_SUB_W)) u_pair (
      .a   (op1[p*2*P_SUB_W +: 2*P_SUB_W]),
      .b   (op2[p*2*P_SUB_W +: 2*P_SUB_W]),
      .wide(eff_wide),
      .m   (mins[p*2*P_SUB_W +: 2*P_SUB_W])
    );
  end

  vmin_lane_ctl #(
    .P_NSUB  (L_NSUB),
    .P_MASK_W(P_MASK_W),
    .P_LEGSUB(LEG_W / P_SUB_W)
  ) u_ctl (
    .vlen     (vlen),
    .wide     (eff_wide),
    .mask     (mask),
    .mask_en  (mask_en),
    .zero_mode(zero_mode),
    .legacy   (legacy),
    .take_min (take_min),
    .take_old (take_old)
  );

  for (genvar j = 0; j < L_NSUB; j++) begin : g_res
    always_comb begin
      if (take_min[j])      res_d[j*P_SUB_W +: P_SUB_W] = mins[j*P_SUB_W +: P_SUB_W];
      else if (take_old[j]) res_d[j*P_SUB_W +: P_SUB_W] = dst_old[j*P_SUB_W +: P_SUB_W];
      else                  res_d[j*P_SUB_W +: P_SUB_W] = '0;
    end
  end

  always_comb begin
    vld_nxt = in_valid;
    res_nxt = in_valid ? res_d : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_nxt;
      res_q <= res_nxt;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

endmodule

// File: rtl/vmin_unit_chk.sv
module vmin_unit_chk #(
  parameter int unsigned P_VEC_W  = 512,
  parameter int unsigned P_SUB_W  = 32,
  parameter int unsigned P_MASK_W = 16,
  parameter int unsigned P_LEG_W  = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [P_VEC_W-1:0]  src_a,
  input logic [P_VEC_W-1:0]  src_b,
  input logic [P_VEC_W-1:0]  dst_old,
  input logic [P_MASK_W-1:0] mask,
  input logic                wide_elem,
  input logic [1:0]          vlen,
  input logic                bcast,
  input logic                mask_en,
  input logic                zero_mode,
  input logic                legacy,
  input logic                out_valid,
  input logic [P_VEC_W-1:0]  result
);

  a_r11_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r11_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && vlen == 2'd0) |=> (result[P_VEC_W-1:P_LEG_W] == '0));

  a_r9_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy) |=> (result[P_VEC_W-1:P_LEG_W] == $past(dst_old[P_VEC_W-1:P_LEG_W])));

  a_r7_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && mask_en && zero_mode && mask == '0) |=> (result == '0));

  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && !mask_en && !bcast && !wide_elem && vlen == 2'd2) |=>
      ((result[P_SUB_W-1:0] <= $past(src_a[P_SUB_W-1:0])) &&
       (result[P_SUB_W-1:0] <= $past(src_b[P_SUB_W-1:0]))));

endmodule

bind vmin_unit vmin_unit_chk #(
  .P_VEC_W (P_VEC_W),
  .P_SUB_W (P_SUB_W),
  .P_MASK_W(P_MASK_W),
  .P_LEG_W (128)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .src_a    (src_a),
  .src_b    (src_b),
  .dst_old  (dst_old),
  .mask     (mask),
  .wide_elem(wide_elem),
  .vlen     (vlen),
  .bcast    (bcast),
  .mask_en  (mask_en),
  .zero_mode(zero_mode),
  .legacy   (legacy),
  .out_valid(out_valid),
  .result   (result)
);

// File: tb/vmin_unit_bench.sv
module vmin_unit_bench;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [511:0] src_a, src_b, dst_old;
  logic [15:0]  mask;
  logic         wide_elem;
  logic [1:0]   vlen;
  logic         bcast, b_mem, mask_en, zero_mode, legacy;
  logic         out_valid;
  logic [511:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vmin_unit u_vmin_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .src_a    (src_a),
    .src_b    (src_b),
    .dst_old  (dst_old),
    .mask     (mask),
    .wide_elem(wide_elem),
    .vlen     (vlen),
    .bcast    (bcast),
    .b_mem    (b_mem),
    .mask_en  (mask_en),
    .zero_mode(zero_mode),
    .legacy   (legacy),
    .out_valid(out_valid),
    .result   (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // Reference result built from the requirements, lane by lane.
  function automatic logic [511:0] model();
    logic [511:0] r, s1;
    int vl;
    s1 = legacy ? dst_old : src_a;
    r  = legacy ? dst_old : '0;
    vl = legacy ? 128 : (vlen == 2'd0 ? 128 : (vlen == 2'd1 ? 256 : 512));
    if (!wide_elem || legacy) begin
      for (int k = 0; k < vl / 32; k++) begin
        logic [31:0] x, y;
        bit en;
        x  = s1[k*32 +: 32];
        y  = (bcast && b_mem && !legacy) ? src_b[31:0] : src_b[k*32 +: 32];
        en = legacy || !mask_en || mask[k];
        if (en) r[k*32 +: 32] = (x < y) ? x : y;
        else if (!zero_mode) r[k*32 +: 32] = dst_old[k*32 +: 32];
      end
    end else begin
      for (int k = 0; k < vl / 64; k++) begin
        logic [63:0] x, y;
        bit en;
        x  = s1[k*64 +: 64];
        y  = (bcast && b_mem) ? src_b[63:0] : src_b[k*64 +: 64];
        en = !mask_en || mask[k];
        if (en) r[k*64 +: 64] = (x < y) ? x : y;
        else if (!zero_mode) r[k*64 +: 64] = dst_old[k*64 +: 64];
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input bit w, input logic [1:0] l, input bit bc, input bit bm,
                         input bit me, input bit zm, input bit lg, input logic [15:0] m);
    wide_elem = w; vlen = l; bcast = bc; b_mem = bm;
    mask_en = me; zero_mode = zm; legacy = lg; mask = m;
  endtask

  // Issue one operation with the current inputs and check its result.
  task automatic issue(input string req);
    logic [511:0] exp;
    @(negedge clk);
    exp = model();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, {511'd0, out_valid}, 512'd1);
    chk(req, result, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    src_a = '0; src_b = '0; dst_old = '0;
    set_ctl(0, 2'd2, 0, 0, 0, 0, 0, 16'h0);
    repeat (2) @(negedge clk);
    chk("R12 out_valid", {511'd0, out_valid}, 512'd0);
    chk("R12 result", result, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_dword();
    set_ctl(0, 2'd2, 0, 0, 0, 0, 0, 16'h0);
    for (int n = 0; n < 4; n++) begin
      src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
      issue("R1 R2 random 32-bit");
    end
    // Ties, extremes and the sign bit read as unsigned.
    src_a = {16{32'h8000_0000}}; src_b = {16{32'h7FFF_FFFF}};
    src_a[31:0] = 32'h1234; src_b[31:0] = 32'h1234;
    src_a[63:32] = 32'hFFFF_FFFF; src_b[63:32] = 32'h0;
    issue("R1 unsigned ties and extremes");
    set_ctl(0, 2'd3, 0, 0, 0, 0, 0, 16'h0);
    src_a = rnd512(); src_b = rnd512();
    issue("R2 code 3 acts as 512");
  endtask

  task automatic t_qword();
    set_ctl(1, 2'd2, 0, 0, 0, 0, 0, 16'h0);
    // High half decides: low half of a smaller than b but a larger overall.
    src_a = {8{64'h0000_0001_0000_0000}};
    src_b = {8{64'h0000_0000_FFFF_FFFF}};
    issue("R3 64-bit compare across halves");
    src_a = rnd512(); src_b = rnd512();
    issue("R3 random 64-bit");
  endtask

  task automatic t_lengths();
    src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
    set_ctl(0, 2'd0, 0, 0, 0, 0, 0, 16'h0);
    issue("R8 128-bit 32-bit lanes");
    set_ctl(1, 2'd1, 0, 0, 0, 0, 0, 16'h0);
    issue("R8 256-bit 64-bit lanes");
    set_ctl(0, 2'd1, 0, 0, 1, 0, 0, 16'hFFFF);
    issue("R8 masked 256-bit");
  endtask

  task automatic t_bcast();
    src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
    set_ctl(0, 2'd2, 1, 1, 0, 0, 0, 16'h0);
    issue("R4 broadcast 32-bit");
    set_ctl(1, 2'd2, 1, 1, 0, 0, 0, 16'h0);
    issue("R4 broadcast 64-bit");
    set_ctl(0, 2'd2, 1, 0, 0, 0, 0, 16'h0);
    issue("R4 broadcast without memory flag");
  endtask

  task automatic t_masking();
    src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
    set_ctl(0, 2'd2, 0, 0, 1, 0, 0, 16'hA5C3);
    issue("R5 R6 merge 32-bit");
    set_ctl(0, 2'd2, 0, 0, 1, 1, 0, 16'h3C96);
    issue("R5 R7 zero 32-bit");
    set_ctl(1, 2'd2, 0, 0, 1, 0, 0, 16'h0059);
    issue("R6 merge 64-bit");
    set_ctl(1, 2'd2, 0, 0, 1, 1, 0, 16'h0000);
    issue("R7 zero all lanes");
    set_ctl(0, 2'd2, 0, 0, 0, 1, 0, 16'h0000);
    issue("R5 mask disabled");
  endtask

  task automatic t_hi_mask();
    src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
    set_ctl(0, 2'd0, 0, 0, 1, 0, 0, 16'hFFF5);
    issue("R10 high mask bits 32-bit 128");
    set_ctl(1, 2'd1, 0, 0, 1, 0, 0, 16'hFFF6);
    issue("R10 high mask bits 64-bit 256");
  endtask

  task automatic t_legacy();
    src_a = '0; src_b = rnd512(); dst_old = rnd512();
    set_ctl(1, 2'd2, 1, 1, 1, 1, 1, 16'h0000);
    issue("R9 legacy ignores src_a mask width broadcast");
    src_a = rnd512();
    issue("R9 legacy other src_a");
  endtask

  task automatic t_hold();
    logic [511:0] prev;
    src_a = rnd512(); src_b = rnd512();
    set_ctl(0, 2'd2, 0, 0, 0, 0, 0, 16'h0);
    issue("R11 issue");
    prev = result;
    src_a = rnd512(); src_b = rnd512();
    @(negedge clk);
    chk("R11 out_valid drops", {511'd0, out_valid}, 512'd0);
    chk("R11 result held", result, prev);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 mid-run result", result, '0);
    chk("R12 mid-run out_valid", {511'd0, out_valid}, 512'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_dword();
    t_qword();
    t_lengths();
    t_bcast();
    t_masking();
    t_hi_mask();
    t_legacy();
    t_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule